// File: doc/BRIEF.md
# Pseudo-Random Density Modulator

This block turns a programmed density word into a single-bit on/off stream for LED dimming. Instead of a linear ramp it compares against the state of a maximal-length linear feedback shift register (LFSR). The state visits every nonzero value exactly once per sequence period, in a scrambled order. The average duty therefore equals the density value, while the output edges are spread across the period. This flattens the emission spectrum compared with plain pulse-width modulation.

Software writes a density word and a width code through a one-cycle write strobe. The width code selects a sequence width N between 4 and 16 bits. The new setting is held in a shadow register. It moves into the active register only when the sequence returns to its starting state, so a period is never made of two settings. An enable input pauses the stream and holds the sequence position.

Top module: `prdm_top`

## Requirements
- R1: While reset is applied and until the first enabled cycle after it, the output is 0. The active setting after reset is width code 0 (N = 4) with density 0, and the sequence state is 1.
- R2: Width code c selects N = c + 4 for c in 0..12; codes 13..15 select N = 16. The sequence state is never zero. With enable high it advances every cycle and repeats after exactly 2^N - 1 cycles. With density 1, output pulses are therefore 2^N - 1 enabled cycles apart.
- R3: The output is registered. After each enabled cycle it is 1 exactly when the sequence state is less than or equal to the low N bits of the active density.
- R4: When the low N bits of the density are 0, the output stays 0 on every cycle.
- R5: When the low N bits of the density are all ones, the output stays 1 on every enabled cycle.
- R6: Over any 2^N - 1 consecutive enabled cycles, the output is high for exactly (density AND (2^N - 1)) cycles. Density bits at N and above have no effect.
- R7: A write is captured into a shadow register. It becomes active in the next enabled cycle in which the sequence state is 1, and it already governs that cycle's comparison. Until then the old density keeps controlling the output.
- R8: A new width is applied together with its density at the same sequence-start cycle. The sequence then runs from state 1 with the new width.
- R9: With enable low, the output is 0 after the next clock edge and the sequence state and active setting hold. When enable returns, the sequence continues from where it stopped, so a pulse is delayed by the number of disabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Modulator enable; low holds the sequence and forces the output low |
| wr_en | input | 1 | One-cycle strobe that captures wr_density and wr_width into the shadow |
| wr_density | input | 16 | Density value; only the low N bits are used |
| wr_width | input | 4 | Width code, N = code + 4, saturating at 16 |
| mod_out | output | 1 | Modulated output bit |

## Verification
A table of width and density pairs is applied: zero, all ones, mid-range, a single state, and a word with ones above bit N. Counting high cycles over one period of each separates a wrong comparison sense, a wrong tap set that shortens the period, and a mask that lets upper density bits through. Programming density 1 gives a single pulse per period. That pulse marks the sequence start, so the bench can measure the period length directly. It can also time a mid-period write, to show the old density holds until the restart. A disable window placed between two such pulses shows whether the position is held, because the next pulse must move back by exactly the number of disabled cycles.

// File: rtl/prdm_pkg.sv
package prdm_pkg;

  localparam int unsigned DW    = 16;
  localparam int unsigned CW    = 4;
  localparam int unsigned MIN_W = 4;
  localparam logic [DW-1:0] SEED = {{(DW-1){1'b0}}, 1'b1};

  function automatic int unsigned width_of(input logic [CW-1:0] code);
    int unsigned n;
    n = int'(code) + MIN_W;
    if (n > DW) n = DW;
    return n;
  endfunction

  function automatic logic [DW-1:0] low_mask(input logic [CW-1:0] code);
    logic [DW:0] t;
    t = ({{DW{1'b0}}, 1'b1} << width_of(code)) - {{DW{1'b0}}, 1'b1};
    return t[DW-1:0];
  endfunction

  // feedback tap positions (bit index = tap - 1) of a maximal polynomial per width
  function automatic logic [DW-1:0] tap_mask(input logic [CW-1:0] code);
    logic [DW-1:0] m;
    case (width_of(code))
      4:       m = 16'h000C;
      5:       m = 16'h0014;
      6:       m = 16'h0030;
      7:       m = 16'h0060;
      8:       m = 16'h00B8;
      9:       m = 16'h0110;
      10:      m = 16'h0240;
      11:      m = 16'h0500;
      12:      m = 16'h0829;
      13:      m = 16'h100D;
      14:      m = 16'h2015;
      15:      m = 16'h6000;
      default: m = 16'hD008;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/prdm_rst_sync.sv
module prdm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/prdm_lfsr.sv
module prdm_lfsr
  import prdm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] code,
  output logic [DW-1:0] state
);
  logic [DW-1:0] state_q, state_d;
  logic          fb;

  always_comb begin
    fb      = ^(state_q & tap_mask(code));
    state_d = state_q;
    if (step) state_d = {state_q[DW-2:0], fb} & low_mask(code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/prdm_setting.sv
module prdm_setting
  import prdm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          at_seed,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_density,
  input  logic [CW-1:0] wr_code,
  output logic [DW-1:0] eff_density,
  output logic [CW-1:0] eff_code,
  output logic [DW-1:0] act_density
);
  logic [DW-1:0] shd_den_q, shd_den_d, act_den_q, act_den_d;
  logic [CW-1:0] shd_code_q, shd_code_d, act_code_q, act_code_d;
  logic          load;

  always_comb begin
    load       = en & at_seed;
    shd_den_d  = wr_en ? wr_density : shd_den_q;
    shd_code_d = wr_en ? wr_code    : shd_code_q;
    act_den_d  = load  ? shd_den_q  : act_den_q;
    act_code_d = load  ? shd_code_q : act_code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_den_q  <= '0;
      shd_code_q <= '0;
      act_den_q  <= '0;
      act_code_q <= '0;
    end else begin
      shd_den_q  <= shd_den_d;
      shd_code_q <= shd_code_d;
      act_den_q  <= act_den_d;
      act_code_q <= act_code_d;
    end
  end

  // the restart cycle is already governed by the incoming setting
  assign eff_density = act_den_d;
  assign eff_code    = act_code_d;
  assign act_density = act_den_q;
endmodule

// File: rtl/prdm_cmp.sv
module prdm_cmp
  import prdm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] state,
  input  logic [DW-1:0] density,
  input  logic [CW-1:0] code,
  output logic          hit
);
  logic hit_q, hit_d;
  logic [DW-1:0] mask;

  always_comb begin
    mask  = low_mask(code);
    hit_d = en & ((state & mask) <= (density & mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign hit = hit_q;
endmodule

// File: rtl/prdm_top.sv
module prdm_top
  import prdm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_density,
  input  logic [CW-1:0] wr_width,
  output logic          mod_out
);
  logic          rst_ns;
  logic [DW-1:0] lfsr_state, eff_density, act_density;
  logic [CW-1:0] eff_code;
  logic          at_seed;

  prdm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  assign at_seed = (lfsr_state == SEED);

  prdm_setting u_set (
    .clk(clk), .rst_n(rst_ns), .en(en), .at_seed(at_seed),
    .wr_en(wr_en), .wr_density(wr_density), .wr_code(wr_width),
    .eff_density(eff_density), .eff_code(eff_code), .act_density(act_density)
  );

  prdm_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_ns), .step(en), .code(eff_code), .state(lfsr_state)
  );

  prdm_cmp u_cmp (
    .clk(clk), .rst_n(rst_ns), .en(en), .state(lfsr_state),
    .density(eff_density), .code(eff_code), .hit(mod_out)
  );
endmodule

// File: rtl/prdm_checker.sv
module prdm_checker
  import prdm_pkg::*;
(
  input logic          clk,
  input logic          rst_ns,
  input logic          en,
  input logic [DW-1:0] lfsr_state,
  input logic [DW-1:0] act_density,
  input logic [DW-1:0] eff_density,
  input logic [CW-1:0] eff_code,
  input logic          mod_out
);
  logic [DW-1:0] eff_mask;
  assign eff_mask = low_mask(eff_code);

  a_r2_state_nonzero: assert property (@(posedge clk) disable iff (!rst_ns)
    lfsr_state != '0);

  a_r2_state_moves: assert property (@(posedge clk) disable iff (!rst_ns)
    en |=> lfsr_state != $past(lfsr_state));

  a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_ns)
    (en && (eff_density & eff_mask) == '0) |=> !mod_out);

  a_r5_full_high: assert property (@(posedge clk) disable iff (!rst_ns)
    (en && (eff_density & eff_mask) == eff_mask) |=> mod_out);

  a_r7_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_ns)
    (lfsr_state != SEED) |=> $stable(act_density));

  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_ns)
    !en |=> !mod_out);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    !en |=> $stable(lfsr_state));
endmodule

bind prdm_top prdm_checker u_chk (
  .clk(clk), .rst_ns(rst_ns), .en(en), .lfsr_state(lfsr_state),
  .act_density(act_density), .eff_density(eff_density),
  .eff_code(eff_code), .mod_out(mod_out)
);

// File: tb/prdm_top_test.sv
module prdm_top_test;
  localparam int CLK_P = 10;
  localparam int NV = 12;
  localparam logic [3:0]  V_CODE [NV] = '{4'd0, 4'd0, 4'd0, 4'd0, 4'd1, 4'd1,
                                          4'd4, 4'd4, 4'd6, 4'd8, 4'd8, 4'd3};
  localparam logic [15:0] V_DEN  [NV] = '{16'h0000, 16'h000F, 16'h0007, 16'h00F5,
                                          16'h001F, 16'h0010, 16'd200, 16'h0001,
                                          16'h03FF, 16'h0800, 16'h0000, 16'd100};
  localparam int V_EXP [NV] = '{0, 15, 7, 5, 31, 16, 200, 1, 1023, 2048, 0, 100};

  logic clk = 1'b0, rst_n, en, wr_en, mod_out;
  logic [15:0] wr_density;
  logic [3:0]  wr_width;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  prdm_top uut (.clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en),
                .wr_density(wr_density), .wr_width(wr_width), .mod_out(mod_out));

  function automatic int period_of(input logic [3:0] c);
    int n;
    n = int'(c) + 4;
    if (n > 16) n = 16;
    return (1 << n) - 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic write_cfg(input logic [3:0] c, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_width = c; wr_density = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mod_out) cnt++;
    end
  endtask

  task automatic find_pulse(output bit found);
    found = 1'b0;
    for (int i = 0; i < 300 && !found; i++) begin
      @(negedge clk);
      if (mod_out) found = 1'b1;
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int cur_p, cnt, gap, lows, highs;
    bit found;
    rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_density = '0; wr_width = '0;
    wait_cycles(4);
    check(mod_out == 1'b0, "R1 out in reset", int'(mod_out), 0);
    rst_n = 1'b1;
    wait_cycles(3);
    en = 1'b1;
    count_high(15, cnt);
    check(cnt == 0, "R1 R4 reset density", cnt, 0);

    // table: R3 R6 count per period; R4 zero, R5 full, R8 width changes, upper bits masked
    cur_p = 15;
    for (int v = 0; v < NV; v++) begin
      write_cfg(V_CODE[v], V_DEN[v]);
      wait_cycles(cur_p + 3);
      cur_p = period_of(V_CODE[v]);
      count_high(cur_p, cnt);
      check(cnt == V_EXP[v], $sformatf("R6 R8 vector %0d", v), cnt, V_EXP[v]);
    end

    // R2 period via single-state pulse
    write_cfg(4'd0, 16'h0001);
    wait_cycles(cur_p + 3);
    find_pulse(found);
    gap = 0; found = 1'b0;
    for (int i = 1; i <= 40 && !found; i++) begin
      @(negedge clk);
      if (mod_out) begin found = 1'b1; gap = i; end
    end
    check(gap == 15, "R2 pulse spacing", gap, 15);

    // R7: write full density right after a pulse; old density governs until restart
    wr_en = 1'b1; wr_width = 4'd0; wr_density = 16'h000F;
    lows = 0;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      if (i == 1) wr_en = 1'b0;
      if (!mod_out) lows++;
    end
    check(lows == 14, "R7 old density kept", lows, 14);
    count_high(15, highs);
    check(highs == 15, "R7 new density at restart", highs, 15);

    // R9: disable window between pulses
    write_cfg(4'd0, 16'h0001);
    wait_cycles(18);
    find_pulse(found);
    gap = 0; lows = 0; found = 1'b0;
    for (int k = 1; k <= 60 && !found; k++) begin
      @(negedge clk);
      if (k >= 5 && k <= 10 && !mod_out) lows++;
      if (mod_out) begin found = 1'b1; gap = k; end
      if (k == 4)  en = 1'b0;
      if (k == 10) en = 1'b1;
    end
    check(lows == 6, "R9 output low while disabled", lows, 6);
    check(gap == 21, "R9 position held", gap, 21);

    finish_up();
  end
endmodule